// File: doc/BRIEF.md
# Mass-storage bus adapter register front end

This block is the register-access front end of a disk/tape bus adapter on a 32-bit system bus. Every bus request is decoded into one of three address spaces: the adapter's own control and status registers, the registers of up to eight attached drives, or a 256-entry map RAM used by the transfer engine. The block enforces the access rules of the adapter and keeps the write-one-to-clear status bits. It tracks a transfer-busy flag: while a transfer runs, some writes become program errors instead of taking effect.

Drive-register accesses are passed on through a simple drive port that answers in the same cycle with ok, missing-drive or missing-register. A write to a drive's command register that carries GO together with a data-transfer function code starts a transfer: busy is set and the clearable status bits are wiped. The data-transfer engine signals the end of a transfer on `xferDone`. Interrupt delivery and the drives themselves sit outside this block.

Top module: `xfer_adapter_regs`

## Requirements
- R1: A request is honoured only when `reqAddr[1:0]` is 0 and `reqSize` is 2 (longword). Any other request changes no state, is not forwarded to a drive, and is answered with code 2 (error) with `errConfirm` high in the response cycle.
- R2: `reqAddr[12:11]` selects the space: 0 adapter registers, 1 drive registers, 2 map RAM, 3 undefined (code 1, nxm). Adapter registers sit at `reqAddr[4:2]`: 0 CNF, 1 CTRL, 2 STAT, 3 VADDR, 4 BCOUNT, 5 DIAG, 7 CMD. Offset 6, nonzero `reqAddr[10:5]` in the adapter space, nonzero `reqAddr[10]` in the other spaces, and writes to CMD answer nxm. CMD reads as 0.
- R3: CNF bits [3:0] are set by `faultSet` and cleared by writing 1 to them (writing 0 keeps them). A CNF read returns these bits ORed with the fixed adapter code in bits [23:16] (default 0x20).
- R4: CTRL bits: 0 INIT, 1 ABORT, 2 IE, 3 MNT; only IE and MNT are stored and read back. INIT clears CNF, STAT, busy, VADDR, BCOUNT, DIAG and the pending interrupt, then IE/MNT of the same write are stored. `intSet` sets the pending interrupt; a CTRL write with IE=0 clears it (clear wins).
- R5: While busy, a CTRL write with ABORT sets STAT bit 16 and pulses `abortReq` in the response cycle; a CTRL write with MNT sets STAT bit 17 (program error) and MNT is not stored. When not busy, neither happens and MNT is stored.
- R6: While busy, writes to VADDR or BCOUNT are dropped and set STAT bit 17. Otherwise VADDR loads bits [16:0], BCOUNT bits [15:0], DIAG bits [7:0]. A BCOUNT read returns the count in bits [15:0] and again in [31:16].
- R7: STAT holds abort (16), program error (17), no-drive (18) and done (19), each cleared by writing 1; busy is bit 31 and read-only. `xferDone` while busy clears busy and sets bit 19; when not busy it has no effect.
- R8: A drive write to register offset 0 with bit 0 (GO) set and function field bits [5:1] at or above 10 is a transfer start. If busy, it sets STAT bit 17 and is not forwarded. Otherwise it is forwarded; an ok reply sets busy and clears STAT bits [19:16].
- R9: Drive accesses carry the drive number from `reqAddr[9:7]`, the register offset from `reqAddr[6:2]` and, on writes, only the low 16 data bits. Drive reply codes: 0 ok, 1 missing drive (sets STAT bit 18, response ok), 2 missing register (response nxm).
- R10: A drive read returns the drive's 16-bit value in bits [15:0] and bits [31:16] of STAT as they stand after the access.
- R11: The map RAM holds 256 entries indexed by `reqAddr[9:2]`; writes store and reads return bits [21:0] only.
- R12: `reqReady` is always high; a request taken in cycle T is answered in cycle T+1 with `respValid`, `respData` and `respCode` (0 ok, 1 nxm, 2 error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request present |
| reqReady | output | 1 | Request accepted (always high) |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 2 | Access size, 2 means longword |
| reqAddr | input | 13 | Byte address inside the adapter window |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | Response cycle |
| respCode | output | 2 | 0 ok, 1 nxm, 2 error |
| respData | output | 32 | Read data |
| errConfirm | output | 1 | Pulse for a rejected unaligned or short access |
| drvReq | output | 1 | Drive register access |
| drvWrite | output | 1 | Drive access is a write |
| drvNum | output | 3 | Drive number |
| drvReg | output | 5 | Drive register offset |
| drvWdata | output | 16 | Drive write data |
| drvRdata | input | 16 | Drive read data, same cycle |
| drvResp | input | 2 | Drive reply: 0 ok, 1 no drive, 2 no register |
| faultSet | input | 4 | Sets CNF fault bits |
| intSet | input | 1 | Raises the pending interrupt |
| intPending | output | 1 | Pending interrupt flag |
| xferDone | input | 1 | Transfer engine finished |
| abortReq | output | 1 | Abort request to the transfer engine |

## Verification
The access rules are swept over every combination of low address bits and size, so the bench separates the single honoured form from all others and confirms through a later read that the rejected write left VADDR untouched. Register loads are tried with all-zero, all-one and mixed patterns, which distinguishes correct field masks and the doubled byte-count read from shifted or truncated ones, and the map is filled with a distinct arithmetic value per entry to expose index or mask mistakes. The busy-dependent paths are run both with and without a transfer in progress, and with function codes just below and at the start threshold, so each program-error and abort effect is shown to depend on busy and on the code. Drive replies of every kind show which one sets the no-drive bit and which one yields nxm, and padded drive reads taken in both states show the status half is live.

// File: rtl/xa_pkg.sv
package xa_pkg;

  localparam int ADDR_W = 13;
  localparam int DRV_NUM_W = 3;
  localparam int DRV_REG_W = 5;

  typedef enum logic [1:0] {
    RESP_OK  = 2'd0,
    RESP_NXM = 2'd1,
    RESP_ERR = 2'd2
  } respCode_e;

  typedef enum logic [1:0] {
    DRV_OK  = 2'd0,
    DRV_NXD = 2'd1,
    DRV_NXR = 2'd2
  } drvCode_e;

  typedef enum logic [3:0] {
    RD_ZERO, RD_CNF, RD_CTRL, RD_STAT, RD_VA, RD_BC, RD_DIAG, RD_DRV, RD_MAP
  } rdSel_e;

  // control-to-datapath strobes, all valid in the request cycle
  typedef struct packed {
    logic   w1cCnf;
    logic   crWrite;
    logic   crInit;
    logic   abortHit;
    logic   mntBlock;
    logic   w1cStat;
    logic   loadVa;
    logic   loadBc;
    logic   loadDiag;
    logic   mapWrite;
    logic   pgeSet;
    logic   nfdSet;
    logic   startOk;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/xa_ctrl.sv
module xa_ctrl
  import xa_pkg::*;
#(
  parameter int DT_FUNC   = 10,
  parameter int MAP_DEPTH = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [5:0]           cmdBits,
  input  logic                 busy,
  input  logic [1:0]           drvResp,
  output strobe_t              st,
  output logic [7:0]           mapIdx,
  output logic                 drvReq,
  output logic                 drvWrite,
  output logic [DRV_NUM_W-1:0] drvNum,
  output logic [DRV_REG_W-1:0] drvReg,
  output logic                 respValid,
  output logic [1:0]           respCode,
  output logic                 errConfirm,
  output logic                 abortReq
);

  localparam logic [4:0] DT_FUNC_V = 5'(DT_FUNC);

  logic       aligned;
  logic [1:0] space;
  logic [2:0] intOfs;
  logic       isStart;
  logic       initBit;
  respCode_e  codeNow;

  assign aligned = (reqAddr[1:0] == 2'b00) && (reqSize == 2'd2);
  assign space   = reqAddr[12:11];
  assign intOfs  = reqAddr[4:2];
  assign drvNum  = reqAddr[9:7];
  assign drvReg  = reqAddr[6:2];
  assign mapIdx  = reqAddr[9:2];
  assign initBit = cmdBits[0];
  assign isStart = reqWrite && (reqAddr[6:2] == '0) && cmdBits[0]
                   && (cmdBits[5:1] >= DT_FUNC_V);
  assign drvWrite = reqWrite;

  always_comb begin
    st      = '0;
    st.rdSel = RD_ZERO;
    codeNow = RESP_OK;
    drvReq  = 1'b0;
    if (reqValid) begin
      if (!aligned) begin
        codeNow = RESP_ERR;
      end else begin
        unique case (space)
          2'd0: begin
            if (reqAddr[10:5] != '0) begin
              codeNow = RESP_NXM;
            end else begin
              unique case (intOfs)
                3'd0: if (reqWrite) st.w1cCnf = 1'b1; else st.rdSel = RD_CNF;
                3'd1: begin
                  if (reqWrite) begin
                    st.crWrite = 1'b1;
                    st.crInit  = initBit;
                    if (busy && !initBit && cmdBits[1]) st.abortHit = 1'b1;
                    if (busy && !initBit && cmdBits[3]) begin
                      st.mntBlock = 1'b1;
                      st.pgeSet   = 1'b1;
                    end
                  end else st.rdSel = RD_CTRL;
                end
                3'd2: if (reqWrite) st.w1cStat = 1'b1; else st.rdSel = RD_STAT;
                3'd3: begin
                  if (reqWrite) begin
                    if (busy) st.pgeSet = 1'b1; else st.loadVa = 1'b1;
                  end else st.rdSel = RD_VA;
                end
                3'd4: begin
                  if (reqWrite) begin
                    if (busy) st.pgeSet = 1'b1; else st.loadBc = 1'b1;
                  end else st.rdSel = RD_BC;
                end
                3'd5: if (reqWrite) st.loadDiag = 1'b1; else st.rdSel = RD_DIAG;
                3'd7: if (reqWrite) codeNow = RESP_NXM; else st.rdSel = RD_ZERO;
                default: codeNow = RESP_NXM;
              endcase
            end
          end
          2'd1: begin
            if (reqAddr[10]) begin
              codeNow = RESP_NXM;
            end else if (isStart && busy) begin
              st.pgeSet = 1'b1;
            end else begin
              drvReq = 1'b1;
              unique case (drvResp)
                DRV_NXD: st.nfdSet = 1'b1;
                DRV_NXR: codeNow = RESP_NXM;
                default: st.startOk = isStart;
              endcase
              if (!reqWrite && drvResp != DRV_NXR) st.rdSel = RD_DRV;
            end
          end
          2'd2: begin
            if (reqAddr[10] || (32'(mapIdx) >= MAP_DEPTH)) codeNow = RESP_NXM;
            else if (reqWrite) st.mapWrite = 1'b1;
            else st.rdSel = RD_MAP;
          end
          default: codeNow = RESP_NXM;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respCode   <= RESP_OK;
      errConfirm <= 1'b0;
      abortReq   <= 1'b0;
    end else begin
      respValid  <= reqValid;
      respCode   <= codeNow;
      errConfirm <= reqValid && (codeNow == RESP_ERR);
      abortReq   <= st.abortHit;
    end
  end

  // R1: a rejected access never reaches a drive
  p_no_fwd_misaligned_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !aligned |-> !drvReq);

  // R1: the error pulse only comes with an error response
  p_errconf_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    errConfirm |-> respValid && respCode == RESP_ERR);

  // R12: every request answered next cycle
  p_resp_next_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R8: a start while busy is dropped
  p_drop_busy_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && aligned && space == 2'd1 && isStart && busy |-> !drvReq);

endmodule

// File: rtl/xa_datapath.sv
module xa_datapath
  import xa_pkg::*;
#(
  parameter int          VA_W         = 17,
  parameter int          BC_W         = 16,
  parameter int          DIAG_W       = 8,
  parameter int          MAP_W        = 22,
  parameter int          MAP_DEPTH    = 256,
  parameter logic [7:0]  ADAPTER_CODE = 8'h20
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic [31:0] wdata,
  input  logic [7:0]  mapIdx,
  input  logic [15:0] drvRdata,
  input  logic [3:0]  faultSet,
  input  logic        intSet,
  input  logic        xferDone,
  output logic        busy,
  output logic        intPending,
  output logic [31:0] respData
);

  localparam int MAP_AW = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1;

  logic [3:0]        cnfBits;
  logic              ctrlIe, ctrlMnt;
  logic [3:0]        statBits;   // abort, program error, no drive, done
  logic [3:0]        statNext;
  logic              busyNext;
  logic [VA_W-1:0]   va;
  logic [BC_W-1:0]   bc;
  logic [DIAG_W-1:0] diag;
  logic [MAP_W-1:0]  mapMem [MAP_DEPTH];
  logic [31:0]       rdNext;
  logic [31:0]       statWord, statWordNext;

  // status next state
  always_comb begin
    statNext = statBits;
    busyNext = busy;
    if (st.crInit) begin
      statNext = '0;
      busyNext = 1'b0;
    end else begin
      if (xferDone && busy) begin
        busyNext    = 1'b0;
        statNext[3] = 1'b1;
      end
      if (st.w1cStat) statNext = statNext & ~wdata[19:16];
      if (st.abortHit) statNext[0] = 1'b1;
      if (st.pgeSet)   statNext[1] = 1'b1;
      if (st.nfdSet)   statNext[2] = 1'b1;
      if (st.startOk) begin
        busyNext = 1'b1;
        statNext = '0;
      end
    end
  end

  assign statWord     = {busy, 11'b0, statBits, 16'b0};
  assign statWordNext = {busyNext, 11'b0, statNext, 16'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statBits <= '0;
      busy     <= 1'b0;
    end else begin
      statBits <= statNext;
      busy     <= busyNext;
    end
  end

  // configuration faults
  always_ff @(posedge clk) begin
    if (!rstN || st.crInit) cnfBits <= '0;
    else cnfBits <= (st.w1cCnf ? (cnfBits & ~wdata[3:0]) : cnfBits) | faultSet;
  end

  // control register and interrupt flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlIe     <= 1'b0;
      ctrlMnt    <= 1'b0;
      intPending <= 1'b0;
    end else begin
      if (st.crWrite) begin
        ctrlIe  <= wdata[2];
        ctrlMnt <= wdata[3] && !st.mntBlock;
      end
      if (st.crInit || (st.crWrite && !wdata[2])) intPending <= 1'b0;
      else if (intSet) intPending <= 1'b1;
    end
  end

  // address, count and diagnostic registers
  always_ff @(posedge clk) begin
    if (!rstN || st.crInit) begin
      va   <= '0;
      bc   <= '0;
      diag <= '0;
    end else begin
      if (st.loadVa)   va   <= wdata[VA_W-1:0];
      if (st.loadBc)   bc   <= wdata[BC_W-1:0];
      if (st.loadDiag) diag <= wdata[DIAG_W-1:0];
    end
  end

  // map RAM, no reset
  always_ff @(posedge clk) begin
    if (st.mapWrite) mapMem[mapIdx[MAP_AW-1:0]] <= wdata[MAP_W-1:0];
  end

  // read mux
  always_comb begin
    unique case (st.rdSel)
      RD_CNF:  rdNext = (32'(ADAPTER_CODE) << 16) | 32'(cnfBits);
      RD_CTRL: rdNext = {28'b0, ctrlMnt, ctrlIe, 2'b00};
      RD_STAT: rdNext = statWord;
      RD_VA:   rdNext = 32'(va);
      RD_BC:   rdNext = (32'(bc) << 16) | 32'(bc);
      RD_DIAG: rdNext = 32'(diag);
      RD_DRV:  rdNext = {statWordNext[31:16], drvRdata};
      RD_MAP:  rdNext = 32'(mapMem[mapIdx[MAP_AW-1:0]]);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) respData <= '0;
    else respData <= rdNext;
  end

  // R8: busy only rises on an accepted start
  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(st.startOk));

  // R8: accepted start leaves no clearable status
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.startOk) |-> statBits == 4'b0000 && busy);

  // R6: address register frozen during a transfer
  p_va_hold_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && !$past(st.crInit) |-> $stable(va));

  // R4: IE written low drops the pending interrupt
  p_ie_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.crWrite && !wdata[2]) |-> !intPending);

  // R5: blocked maintenance bit is not stored
  p_mnt_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.mntBlock) |-> !ctrlMnt);

endmodule

// File: rtl/xfer_adapter_regs.sv
module xfer_adapter_regs
  import xa_pkg::*;
#(
  parameter int          VA_W         = 17,
  parameter int          BC_W         = 16,
  parameter int          DIAG_W       = 8,
  parameter int          MAP_W        = 22,
  parameter int          MAP_DEPTH    = 256,
  parameter int          DT_FUNC      = 10,
  parameter logic [7:0]  ADAPTER_CODE = 8'h20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [12:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        respValid,
  output logic [1:0]  respCode,
  output logic [31:0] respData,
  output logic        errConfirm,
  output logic        drvReq,
  output logic        drvWrite,
  output logic [2:0]  drvNum,
  output logic [4:0]  drvReg,
  output logic [15:0] drvWdata,
  input  logic [15:0] drvRdata,
  input  logic [1:0]  drvResp,
  input  logic [3:0]  faultSet,
  input  logic        intSet,
  output logic        intPending,
  input  logic        xferDone,
  output logic        abortReq
);

  strobe_t    st;
  logic       busy;
  logic [7:0] mapIdx;

  assign reqReady = 1'b1;
  assign drvWdata = reqWdata[15:0];

  xa_ctrl #(
    .DT_FUNC  (DT_FUNC),
    .MAP_DEPTH(MAP_DEPTH)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .reqAddr   (reqAddr),
    .cmdBits   (reqWdata[5:0]),
    .busy      (busy),
    .drvResp   (drvResp),
    .st        (st),
    .mapIdx    (mapIdx),
    .drvReq    (drvReq),
    .drvWrite  (drvWrite),
    .drvNum    (drvNum),
    .drvReg    (drvReg),
    .respValid (respValid),
    .respCode  (respCode),
    .errConfirm(errConfirm),
    .abortReq  (abortReq)
  );

  xa_datapath #(
    .VA_W        (VA_W),
    .BC_W        (BC_W),
    .DIAG_W      (DIAG_W),
    .MAP_W       (MAP_W),
    .MAP_DEPTH   (MAP_DEPTH),
    .ADAPTER_CODE(ADAPTER_CODE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .wdata     (reqWdata),
    .mapIdx    (mapIdx),
    .drvRdata  (drvRdata),
    .faultSet  (faultSet),
    .intSet    (intSet),
    .xferDone  (xferDone),
    .busy      (busy),
    .intPending(intPending),
    .respData  (respData)
  );

endmodule

// File: tb/xfer_adapter_regs_tb_top.sv
`timescale 1ns/1ps
module xfer_adapter_regs_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd2;
  logic [12:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, respValid, errConfirm, drvReq, drvWrite, intPending, abortReq;
  logic [1:0]  respCode, drvResp;
  logic [31:0] respData;
  logic [2:0]  drvNum;
  logic [4:0]  drvReg;
  logic [15:0] drvWdata, drvRdata;
  logic [3:0]  faultSet = '0;
  logic        intSet = 1'b0, xferDone = 1'b0;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  xfer_adapter_regs dut_i (.*);

  // drive stub: drives 0..5 exist, register offsets 0..15 exist
  logic [15:0] drvMem [8][32];
  always_comb begin
    if (drvNum >= 3'd6) begin
      drvResp = 2'd1;
      drvRdata = '0;
    end else if (drvReg >= 5'd16) begin
      drvResp = 2'd2;
      drvRdata = '0;
    end else begin
      drvResp = 2'd0;
      drvRdata = drvMem[drvNum][drvReg];
    end
  end
  always @(posedge clk)
    if (drvReq && drvWrite && drvResp == 2'd0) drvMem[drvNum][drvReg] <= drvWdata;

  localparam logic [31:0] CNF_BASE = 32'h0020_0000;
  localparam logic [31:0] VA_MASK = 32'h0001_FFFF;
  localparam logic [31:0] MAP_MASK = 32'h003F_FFFF;

  function automatic logic [12:0] intA(input int ofs);
    return 13'(ofs << 2);
  endfunction
  function automatic logic [12:0] drvA(input int n, input int r);
    return 13'h0800 | 13'(n << 7) | 13'(r << 2);
  endfunction
  function automatic logic [12:0] mapA(input int i);
    return 13'h1000 | 13'(i << 2);
  endfunction
  function automatic logic [31:0] mapVal(input int i);
    return 32'(i) * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  logic [31:0] rd;
  logic [1:0]  rc;
  logic        ec, ab;

  // called at a falling edge; returns with response sampled in cycle T+1
  task automatic access(input bit wr, input logic [12:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqSize  = sz;
    reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
    rd = respData;
    rc = respCode;
    ec = errConfirm;
    ab = abortReq;
    if (respValid !== 1'b1) begin
      nChecks++;
      nFail++;
      $display("FAIL R12 respValid actual=%b expected=1", respValid);
    end
  endtask

  task automatic wr32(input logic [12:0] a, input logic [31:0] wd);
    access(1'b1, a, 2'd2, wd);
  endtask
  task automatic rd32(input logic [12:0] a);
    access(1'b0, a, 2'd2, 32'h0);
  endtask

  task automatic pulseIn(input int which, input logic [3:0] f);
    if (which == 0) faultSet = f;
    else if (which == 1) intSet = 1'b1;
    else xferDone = 1'b1;
    @(negedge clk);
    faultSet = '0;
    intSet = 1'b0;
    xferDone = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int d = 0; d < 8; d++)
      for (int r = 0; r < 32; r++) drvMem[d][r] = 16'hA000 | 16'(d << 8) | 16'(r);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R12 reset respValid", 32'(respValid), 32'h0);
    chk("R12 reqReady", 32'(reqReady), 32'h1);
    rd32(intA(2)); chk("R7 reset STAT", rd, 32'h0);
    chk("R12 ok code", 32'(rc), 32'h0);
    rd32(intA(1)); chk("R4 reset CTRL", rd, 32'h0);
    rd32(intA(3)); chk("R6 reset VADDR", rd, 32'h0);
    rd32(intA(0)); chk("R3 reset CNF code", rd, CNF_BASE);

    // R1 sweep of offset and size
    for (int off = 0; off < 4; off++)
      for (int sz = 0; sz < 4; sz++) begin
        if (off == 0 && sz == 2) continue;
        access(1'b1, intA(3) | 13'(off), 2'(sz), 32'h0000_1234);
        chk("R1 bad access code", 32'(rc), 32'h2);
        chk("R1 errConfirm", 32'(ec), 32'h1);
        rd32(intA(3));
        chk("R1 VADDR untouched", rd, 32'h0);
        chk("R1 no errConfirm on good", 32'(ec), 32'h0);
      end
    access(1'b1, drvA(2, 3) | 13'd2, 2'd2, 32'h0000_5555);
    rd32(drvA(2, 3)); chk("R1 drive not written", rd, 32'h0000_A203);

    // R6 register loads
    begin
      logic [31:0] pats [4] = '{32'h0, 32'hFFFF_FFFF, 32'h0001_5A5A, 32'h8000_0001};
      foreach (pats[k]) begin
        wr32(intA(3), pats[k]); rd32(intA(3)); chk("R6 VADDR", rd, pats[k] & VA_MASK);
        wr32(intA(4), pats[k]); rd32(intA(4));
        chk("R6 BCOUNT doubled", rd, {pats[k][15:0], pats[k][15:0]});
        wr32(intA(5), pats[k]); rd32(intA(5)); chk("R6 DIAG", rd, pats[k] & 32'hFF);
      end
    end

    // R2 decode
    rd32(intA(6)); chk("R2 offset 6 nxm", 32'(rc), 32'h1); chk("R2 nxm data", rd, 32'h0);
    wr32(intA(7), 32'hFFFF_FFFF); chk("R2 CMD write nxm", 32'(rc), 32'h1);
    rd32(intA(7)); chk("R2 CMD read code", 32'(rc), 32'h0); chk("R2 CMD reads zero", rd, 32'h0);
    rd32(13'h1800); chk("R2 space 3 nxm", 32'(rc), 32'h1);
    rd32(13'h0040); chk("R2 high internal bits nxm", 32'(rc), 32'h1);
    rd32(13'h0C00); chk("R2 drive bit10 nxm", 32'(rc), 32'h1);

    // R3 configuration faults
    pulseIn(0, 4'hF);
    rd32(intA(0)); chk("R3 faults set", rd, CNF_BASE | 32'hF);
    wr32(intA(0), 32'h5); rd32(intA(0)); chk("R3 write one clears", rd, CNF_BASE | 32'hA);
    wr32(intA(0), 32'h0); rd32(intA(0)); chk("R3 write zero keeps", rd, CNF_BASE | 32'hA);
    wr32(intA(0), 32'hF);

    // R11 map sweep
    for (int i = 0; i < 256; i++) wr32(mapA(i), mapVal(i));
    for (int i = 0; i < 256; i++) begin
      rd32(mapA(i)); chk("R11 map entry", rd, mapVal(i) & MAP_MASK);
    end

    // R9 / R10 drive access
    wr32(drvA(2, 5), 32'hDEAD_BEEF); chk("R9 drive write code", 32'(rc), 32'h0);
    rd32(drvA(2, 5)); chk("R10 drive read idle", rd, 32'h0000_BEEF);
    wr32(drvA(6, 1), 32'h1111); chk("R9 missing drive ok code", 32'(rc), 32'h0);
    rd32(intA(2)); chk("R9 NFD set", rd, 32'h0004_0000);
    wr32(intA(2), 32'h0004_0000); rd32(intA(2)); chk("R7 NFD cleared", rd, 32'h0);
    rd32(drvA(7, 1)); chk("R10 padded with fresh NFD", rd, 32'h0004_0000);
    rd32(drvA(1, 20)); chk("R9 missing register nxm", 32'(rc), 32'h1);
    wr32(drvA(1, 20), 32'h1); chk("R9 missing register write nxm", 32'(rc), 32'h1);

    // R8 transfer start
    wr32(drvA(3, 0), 32'h0000_0015); chk("R8 start code", 32'(rc), 32'h0);
    chk("R8 start forwarded", 32'(drvMem[3][0]), 32'h0015);
    rd32(intA(2)); chk("R8 busy set, W1C cleared", rd, 32'h8000_0000);
    wr32(drvA(4, 0), 32'h0000_0013);
    chk("R8 below threshold forwarded", 32'(drvMem[4][0]), 32'h0013);
    rd32(intA(2)); chk("R8 below threshold no error", rd, 32'h8000_0000);
    wr32(drvA(4, 0), 32'h0000_0015); chk("R8 busy start code", 32'(rc), 32'h0);
    chk("R8 busy start dropped", 32'(drvMem[4][0]), 32'h0013);
    rd32(intA(2)); chk("R8 busy start PGE", rd, 32'h8002_0000);

    // R6 busy rejection
    wr32(intA(2), 32'h0002_0000);
    rd32(intA(2)); chk("R7 PGE cleared", rd, 32'h8000_0000);
    wr32(intA(3), 32'h777); rd32(intA(3)); chk("R6 VADDR held busy", rd, 32'h1);
    rd32(intA(2)); chk("R6 VADDR busy PGE", rd, 32'h8002_0000);
    wr32(intA(2), 32'h0002_0000);
    wr32(intA(4), 32'h4321); rd32(intA(4)); chk("R6 BCOUNT held busy", rd, 32'h0001_0001);
    rd32(intA(2)); chk("R6 BCOUNT busy PGE", rd, 32'h8002_0000);
    rd32(drvA(2, 5)); chk("R10 drive read busy", rd, 32'h8002_BEEF);

    // R5 busy MNT and ABORT
    wr32(intA(2), 32'h0002_0000);
    wr32(intA(1), 32'h0C); rd32(intA(1)); chk("R5 MNT not stored busy", rd, 32'h04);
    rd32(intA(2)); chk("R5 MNT busy PGE", rd, 32'h8002_0000);
    wr32(intA(2), 32'h0002_0000);
    wr32(intA(1), 32'h06); chk("R5 abortReq pulse", 32'(ab), 32'h1);
    rd32(intA(2)); chk("R5 abort status", rd, 32'h8001_0000);
    chk("R5 abortReq single", 32'(ab), 32'h0);

    // R7 completion
    pulseIn(2, 4'h0);
    rd32(intA(2)); chk("R7 done clears busy", rd, 32'h0009_0000);
    wr32(intA(2), 32'h000F_0000);
    pulseIn(2, 4'h0);
    rd32(intA(2)); chk("R7 done ignored idle", rd, 32'h0);
    wr32(intA(1), 32'h0C); rd32(intA(1)); chk("R5 MNT stored idle", rd, 32'h0C);
    rd32(intA(2)); chk("R5 no PGE idle", rd, 32'h0);
    wr32(intA(1), 32'h06); chk("R5 no abort idle", 32'(ab), 32'h0);
    rd32(intA(2)); chk("R5 no abort status idle", rd, 32'h0);

    // R4 interrupt flag and INIT
    pulseIn(1, 4'h0); chk("R4 intSet", 32'(intPending), 32'h1);
    wr32(intA(1), 32'h04); chk("R4 IE=1 keeps pending", 32'(intPending), 32'h1);
    wr32(intA(1), 32'h00); chk("R4 IE=0 clears", 32'(intPending), 32'h0);
    pulseIn(1, 4'h0); chk("R4 pending again", 32'(intPending), 32'h1);
    wr32(drvA(3, 0), 32'h0000_0017);
    pulseIn(0, 4'h3);
    wr32(intA(2), 32'h0);
    rd32(intA(2)); chk("R8 restarted", rd, 32'h8000_0000);
    wr32(intA(1), 32'h05);
    chk("R4 INIT clears pending", 32'(intPending), 32'h0);
    rd32(intA(2)); chk("R4 INIT clears STAT", rd, 32'h0);
    rd32(intA(3)); chk("R4 INIT clears VADDR", rd, 32'h0);
    rd32(intA(4)); chk("R4 INIT clears BCOUNT", rd, 32'h0);
    rd32(intA(5)); chk("R4 INIT clears DIAG", rd, 32'h0);
    rd32(intA(0)); chk("R4 INIT clears CNF", rd, CNF_BASE);
    rd32(intA(1)); chk("R4 IE stored with INIT", rd, 32'h04);
    rd32(mapA(5)); chk("R11 map kept over INIT", rd, mapVal(5) & MAP_MASK);

    finishRun();
  end

endmodule